// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block runs on the host side of a 16-bit expansion bus and decides how long each bus cycle lasts. When a cycle is requested, it holds the cycle open for one base clock plus a default number of wait states. That default depends on the transfer width: narrow 8-bit transfers get a long stretch, and wide 16-bit transfers get a short one.

A target on the bus can drive an active-low zero-wait input to end the cycle at once. The controller reports an open cycle on a busy flag. It marks the end of each cycle with a one-clock done strobe. While a cycle is open, it ignores any new request.

Command strobes, address decoding and ready-line stretching beyond the default are left to neighbouring logic. Both wait counts are parameters; the defaults are 4 for narrow transfers and 1 for wide ones.

Top module: `bus_wait_ctrl`

## Requirements
- R1: While rst_ni is low, busy_o and done_o are low, and they stay low after reset until a request is accepted.
- R2: A request (start_i high) sampled on a rising edge while busy_o is low is accepted, and busy_o is high in the following cycle.
- R3: A request accepted with wide_i low (8-bit) keeps busy_o high for 5 cycles (1 base plus 4 wait states), then done_o pulses, unless zero-wait intervenes.
- R4: A request accepted with wide_i high (16-bit) keeps busy_o high for 2 cycles (1 base plus 1 wait state), then done_o pulses, unless zero-wait intervenes.
- R5: zws_ni sampled low on any rising edge while busy_o is high ends the cycle: after that edge busy_o is low and done_o is high.
- R6: zws_ni has no effect while busy_o is low: with no request, busy_o and done_o stay low whatever zws_ni does.
- R7: done_o is high for exactly one cycle per accepted request, with busy_o low in that cycle. busy_o is high in every cycle from acceptance until the done cycle.
- R8: start_i sampled while busy_o is high is ignored: the open cycle keeps its length, and no further cycle follows it.
- R9: The transfer width is taken only on the accepting edge; changes on wide_i during an open cycle do not change its length.
- R10: A request sampled during the done cycle is accepted, so cycles can run back to back with a single done cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Cycle request |
| wide_i | input | 1 | Transfer width: 1 = 16-bit, 0 = 8-bit |
| zws_ni | input | 1 | Zero-wait request from the target, active low |
| busy_o | output | 1 | Cycle open |
| done_o | output | 1 | One-clock end-of-cycle strobe |

## Verification
Both widths are first run with zws_ni held high. This checks that 8-bit and 16-bit transfers get different default lengths.

Zero-wait is then asserted in the first, a middle and the last busy cycle. Comparing these runs shows that the cut point follows the exact cycle in which the input was sampled, and that a late assertion cannot lengthen a cycle.

Further runs hold zws_ni low while idle, toggle wide_i mid-cycle, and raise start_i while busy. These show that such inputs matter only at the intended edges. Back-to-back requests confirm that a request is accepted during the done cycle.

// File: rtl/bwc_pkg.sv
`timescale 1ns/1ps
package bwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bwc_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bwc_wait_sel.sv
`timescale 1ns/1ps
module bwc_wait_sel #(
  parameter int NARROW_WAITS = 4,
  parameter int WIDE_WAITS   = 1,
  parameter int CNT_W        = 3
) (
  input  logic             wide_i,
  output logic [CNT_W-1:0] waits_o
);
  localparam logic [CNT_W-1:0] NarrowCnt = CNT_W'(NARROW_WAITS);
  localparam logic [CNT_W-1:0] WideCnt   = CNT_W'(WIDE_WAITS);

  always_comb waits_o = wide_i ? WideCnt : NarrowCnt;
endmodule

// File: rtl/bwc_wait_cnt.sv
`timescale 1ns/1ps
module bwc_wait_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bwc_seq.sv
`timescale 1ns/1ps
module bwc_seq
  import bwc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic zws_ni,
  input  logic cnt_zero_i,
  output logic load_o,
  output logic dec_o,
  output logic busy_o,
  output logic done_o
);
  bwc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    dec_o   = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        // done cycle also accepts, giving back-to-back cycles
        if (start_i) begin
          state_d = ST_RUN;
          load_o  = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_RUN: begin
        if (!zws_ni || cnt_zero_i) state_d = ST_DONE;
        else                       dec_o   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/bus_wait_ctrl.sv
`timescale 1ns/1ps
module bus_wait_ctrl #(
  parameter int NARROW_WAITS = 4,
  parameter int WIDE_WAITS   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wide_i,
  input  logic zws_ni,
  output logic busy_o,
  output logic done_o
);
  localparam int MaxWaits = bwc_pkg::max_int(NARROW_WAITS, WIDE_WAITS);
  localparam int CntW     = (MaxWaits < 1) ? 1 : $clog2(MaxWaits + 1);

  logic [CntW-1:0] waits;
  logic            load, dec, cnt_zero;

  bwc_wait_sel #(
    .NARROW_WAITS(NARROW_WAITS),
    .WIDE_WAITS  (WIDE_WAITS),
    .CNT_W       (CntW)
  ) i_sel (
    .wide_i (wide_i),
    .waits_o(waits)
  );

  bwc_wait_cnt #(.CNT_W(CntW)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(waits),
    .dec_i     (dec),
    .zero_o    (cnt_zero)
  );

  bwc_seq i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .zws_ni    (zws_ni),
    .cnt_zero_i(cnt_zero),
    .load_o    (load),
    .dec_o     (dec),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/bwc_chk.sv
`timescale 1ns/1ps
module bwc_chk #(
  parameter int NARROW_WAITS = 4,
  parameter int WIDE_WAITS   = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic wide_i,
  input logic zws_ni,
  input logic busy_o,
  input logic done_o
);
  int   len_q;
  logic wide_q, zws_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q      <= 0;
      wide_q     <= 1'b0;
      zws_seen_q <= 1'b0;
    end else begin
      if (done_o) begin
        len_q      <= 0;
        zws_seen_q <= 1'b0;
      end
      if (busy_o) begin
        len_q <= len_q + 1;
        if (!zws_ni) zws_seen_q <= 1'b1;
      end
      if (start_i && !busy_o) wide_q <= wide_i;
    end
  end

  // R2, R10
  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R5
  assert_zws_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !zws_ni) |=> (done_o && !busy_o));
  // R7
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_not_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));
  assert_done_after_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> len_q != 0);
  // R3
  assert_narrow_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !zws_seen_q && !wide_q) |-> len_q == NARROW_WAITS + 1);
  // R4
  assert_wide_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !zws_seen_q && wide_q) |-> len_q == WIDE_WAITS + 1);
  // R6
  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);
endmodule

bind bus_wait_ctrl bwc_chk #(
  .NARROW_WAITS(NARROW_WAITS),
  .WIDE_WAITS  (WIDE_WAITS)
) i_bwc_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .wide_i (wide_i),
  .zws_ni (zws_ni),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/test_bus_wait_ctrl.sv
`timescale 1ns/1ps
module test_bus_wait_ctrl;
  localparam int NarrowWaits = 4;
  localparam int WideWaits   = 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, wide_i = 1'b0, zws_ni = 1'b1;
  logic busy_o, done_o;

  int n_checks = 0, n_errors = 0;
  int exp_q[$];
  int mon_len = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bus_wait_ctrl #(.NARROW_WAITS(NarrowWaits), .WIDE_WAITS(WideWaits)) i_bus_wait_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .wide_i(wide_i),
    .zws_ni(zws_ni), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: counts busy cycles, compares at each done strobe
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (busy_o) mon_len++;
      if (done_o) begin
        if (exp_q.size() == 0) check("R7 unexpected done", 1, 0);
        else check("R3/R4/R5/R8/R9 busy length", mon_len, exp_q.pop_front());
        mon_len = 0;
      end
    end
  end

  // driver: zk = busy cycle in which zws_ni is low (0 = never)
  task automatic run_cycle(input logic wide, input int zk, input bit noisy);
    int def_len = (wide ? WideWaits : NarrowWaits) + 1;
    int exp_len = (zk > 0 && zk <= def_len) ? zk : def_len;
    int i = 1;
    exp_q.push_back(exp_len);
    start_i = 1'b1;
    wide_i  = wide;
    @(negedge clk_i);
    check("R2 busy after accept", busy_o, 1);
    start_i = 1'b0;
    forever begin
      zws_ni = (i == zk) ? 1'b0 : 1'b1;
      if (noisy) begin
        start_i = 1'b1;      // R8: ignored while busy
        wide_i  = ~wide;     // R9: width not re-sampled
      end
      @(negedge clk_i);
      if (!busy_o) break;
      i++;
    end
    zws_ni  = 1'b1;
    start_i = 1'b0;
    check("R7 done strobe", done_o, 1);
    check("R7 busy low in done", busy_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    // R1
    repeat (3) @(negedge clk_i);
    check("R1 busy in reset", busy_o, 0);
    check("R1 done in reset", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 busy after reset", busy_o, 0);
    check("R1 done after reset", done_o, 0);

    // R6: zero-wait while idle has no effect
    zws_ni = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      check("R6 idle busy", busy_o, 0);
      check("R6 idle done", done_o, 0);
    end
    zws_ni = 1'b1;

    run_cycle(1'b0, 0, 1'b0);   // R3 default narrow
    @(negedge clk_i);
    run_cycle(1'b1, 0, 1'b0);   // R4 default wide
    @(negedge clk_i);
    run_cycle(1'b0, 1, 1'b0);   // R5 first cycle
    @(negedge clk_i);
    run_cycle(1'b0, 3, 1'b0);   // R5 middle
    @(negedge clk_i);
    run_cycle(1'b0, 5, 1'b0);   // R5 last cycle
    @(negedge clk_i);
    run_cycle(1'b1, 1, 1'b0);   // R5 wide cut
    @(negedge clk_i);

    // R8, R9: start and width toggled while busy
    run_cycle(1'b0, 0, 1'b1);
    @(negedge clk_i);
    check("R8 no extra cycle busy", busy_o, 0);
    check("R8 no extra cycle done", done_o, 0);
    run_cycle(1'b1, 0, 1'b1);
    @(negedge clk_i);
    check("R8 no extra cycle after wide", busy_o, 0);

    // R10: back to back, request during done cycle
    run_cycle(1'b1, 0, 1'b0);
    run_cycle(1'b0, 0, 1'b0);
    run_cycle(1'b1, 2, 1'b0);
    @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    check("R7 all cycles completed", exp_q.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule